// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a byte-wide parallel flash memory and turns single-cycle writes into commands. Most commands require an unlock prefix of two writes. A command write follows the prefix. Program and erase then need further writes. When a sequence completes, the decoder sends a one-cycle request to the program/erase engine. The request is one of: program a byte, erase a set of sectors, erase the whole array, suspend an erase, or resume an erase. A write that breaks a sequence abandons it.

The decoder also holds the read mode. Reads either come from the array, or they return identification codes and per-sector protection status. The read selection and the identification byte are decoded combinationally from the read address.

Sector erase keeps a window open after the first sector is named. More sector-erase writes inside that window add their sectors to the set. The erase request is issued when the window expires without a new write.

Top module: `fcd`

## Requirements
- R1: After reset the decoder is in array-read mode (`rd_sel` = 00, `rd_data` = 00h) and every request output is low.
- R2: Unlock steps are a write of AAh at address 5555h and then a write of 55h at address 2AAAh. Only address bits [14:0] are compared, so the upper address bits are don't-care.
- R3: Unlock followed by A0h at 5555h arms programming. The next write of any value at any address raises `prog_req` with that address on `prog_addr` and that byte on `prog_data`.
- R4: Unlock, 80h at 5555h, unlock again, then 10h at 5555h raises `erase_req` with `erase_bulk` = 1 and `erase_sectors` = all ones.
- R5: The same erase prefix followed by 30h at any address opens a window of WIN_CYC cycles. The sector index is address bits [18:16], and bit n of `erase_sectors` marks sector n. Each further 30h write inside the window adds its sector and restarts the window. `erase_req` (with `erase_bulk` = 0) appears exactly WIN_CYC cycles after the last such write.
- R6: From idle, a single B0h write raises `suspend_req` only while `erase_busy` is high. A single 30h write raises `resume_req` only while `erase_suspended` is high. Otherwise both writes are ignored, and the read mode and state are unchanged.
- R7: A write of F0h at any address returns the decoder to idle in array-read mode, from any step except the program data step.
- R8: Any write that does not match the expected step abandons the sequence and returns to idle in array-read mode with no request. This includes a non-30h write inside an erase window, which cancels the erase.
- R9: Unlock followed by 90h at 5555h selects identification mode. There, with address bits A6 and A1 low, `rd_sel` = 01 and `rd_data` is 20h when A0 is 0 and E2h when A0 is 1.
- R10: In identification mode, A1 high with A0 and A6 low gives `rd_sel` = 10 and `rd_data` = 01h if `prot_mask` bit [A18:A16] is set, 00h otherwise.
- R11: Every request is registered. It is high for exactly the one cycle after the clock edge that accepts the completing write (or, for sector erase, the edge that ends the window). At most one request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| erase_busy | input | 1 | Engine is erasing |
| erase_suspended | input | 1 | Engine holds a suspended erase |
| rd_addr | input | 19 | Read address for mode decode |
| prot_mask | input | 8 | Per-sector protection flags |
| prog_req | output | 1 | Program byte request |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program byte |
| erase_req | output | 1 | Erase request |
| erase_bulk | output | 1 | Erase request covers whole array |
| erase_sectors | output | 8 | Sectors to erase |
| suspend_req | output | 1 | Erase suspend request |
| resume_req | output | 1 | Erase resume request |
| rd_sel | output | 2 | 00 array, 01 identification code, 10 protection status |
| rd_data | output | 8 | Identification or status byte |

## Verification
Requests come from registers. Each one is sampled on the falling edge that follows the rising edge that accepted the completing write. At that point, a request that must not appear is also checked as low. The sector-erase window is counted edge by edge after the last 30h write. The request must still be low one edge before WIN_CYC and must be high exactly at WIN_CYC. The read selection and identification byte are combinational in the mode register and `rd_addr`, so they are checked one nanosecond after `rd_addr` changes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PGM,
        ST_EUNL0,
        ST_EUNL1,
        ST_EUNL2,
        ST_WIN
    } fcd_state_e;

    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_PGM     = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_BULK    = 8'h10;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [14:0] ADR_FIRST  = 15'h5555;
    localparam logic [14:0] ADR_SECOND = 15'h2AAA;
    localparam logic [7:0] ID_MAKER    = 8'h20;
    localparam logic [7:0] ID_DEVICE   = 8'hE2;

    typedef enum logic [1:0] {
        RSEL_ARRAY = 2'b00,
        RSEL_IDENT = 2'b01,
        RSEL_PROT  = 2'b10
    } fcd_rsel_e;
endpackage

// File: rtl/fcd_match.sv
module fcd_match #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              key1_hit,
    output logic              key2_hit,
    output logic              cmd_adr,
    output logic [SECT_W-1:0] sector
);
    import fcd_pkg::*;
    localparam int SECT_LSB = ADDR_W - SECT_W;

    always_comb begin
        cmd_adr  = (addr[14:0] == ADR_FIRST);
        key1_hit = cmd_adr && (data == KEY_FIRST);
        key2_hit = (addr[14:0] == ADR_SECOND) && (data == KEY_SECOND);
        sector   = addr[ADDR_W-1:SECT_LSB];
    end
endmodule

// File: rtl/fcd_readout.sv
module fcd_readout #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic                  ident_mode,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [(1<<SECT_W)-1:0] prot_mask,
    output logic [1:0]            rd_sel,
    output logic [7:0]            rd_data
);
    import fcd_pkg::*;
    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic [SECT_W-1:0] sec;
    assign sec = rd_addr[ADDR_W-1:SECT_LSB];

    always_comb begin
        rd_sel  = RSEL_ARRAY;
        rd_data = 8'h00;
        if (ident_mode) begin
            if (rd_addr[1] && !rd_addr[0] && !rd_addr[6]) begin
                rd_sel  = RSEL_PROT;
                rd_data = {7'b0, prot_mask[sec]};
            end else begin
                rd_sel = RSEL_IDENT;
                if (!rd_addr[6] && !rd_addr[1])
                    rd_data = rd_addr[0] ? ID_DEVICE : ID_MAKER;
            end
        end
    end
endmodule

// File: rtl/fcd.sv
module fcd #(
    parameter int ADDR_W  = 19,
    parameter int SECT_W  = 3,
    parameter int WIN_CYC = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic                    erase_busy,
    input  logic                    erase_suspended,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [(1<<SECT_W)-1:0]  prot_mask,
    output logic                    prog_req,
    output logic [ADDR_W-1:0]       prog_addr,
    output logic [7:0]              prog_data,
    output logic                    erase_req,
    output logic                    erase_bulk,
    output logic [(1<<SECT_W)-1:0]  erase_sectors,
    output logic                    suspend_req,
    output logic                    resume_req,
    output logic [1:0]              rd_sel,
    output logic [7:0]              rd_data
);
    import fcd_pkg::*;
    localparam int NSECT = 1 << SECT_W;
    localparam int CNT_W = $clog2(WIN_CYC + 1);

    typedef struct packed {
        fcd_state_e        st;
        logic              ident;
        logic [CNT_W-1:0]  cnt;
        logic [NSECT-1:0]  mask;
        logic              bulk;
        logic              prog;
        logic              erase;
        logic              susp;
        logic              resume;
        logic [ADDR_W-1:0] paddr;
        logic [7:0]        pdata;
    } fcd_regs_t;

    fcd_regs_t r_q, r_d;

    logic              key1_hit, key2_hit, cmd_adr;
    logic [SECT_W-1:0] wsec;

    fcd_match #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_match (
        .addr(wr_addr), .data(wr_data),
        .key1_hit(key1_hit), .key2_hit(key2_hit),
        .cmd_adr(cmd_adr), .sector(wsec)
    );

    fcd_readout #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_read (
        .ident_mode(r_q.ident), .rd_addr(rd_addr), .prot_mask(prot_mask),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always_comb begin
        logic abort;
        logic [NSECT-1:0] sec_bit;
        abort    = 1'b0;
        sec_bit  = '0;
        sec_bit[wsec] = 1'b1;
        r_d        = r_q;
        r_d.prog   = 1'b0;
        r_d.erase  = 1'b0;
        r_d.susp   = 1'b0;
        r_d.resume = 1'b0;

        if (r_q.st == ST_WIN && !wr_en) begin
            if (r_q.cnt == '0) begin
                r_d.erase = 1'b1;
                r_d.bulk  = 1'b0;
                r_d.st    = ST_IDLE;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end

        if (wr_en) begin
            if (r_q.st != ST_PGM && wr_data == CMD_RESET) begin
                r_d.st    = ST_IDLE;
                r_d.ident = 1'b0;
            end else begin
                unique case (r_q.st)
                    ST_IDLE: begin
                        if (key1_hit)
                            r_d.st = ST_UNL1;
                        else if (wr_data == CMD_SUSPEND) begin
                            if (erase_busy) begin
                                r_d.susp  = 1'b1;
                                r_d.ident = 1'b0;
                            end
                        end else if (wr_data == CMD_SECTOR) begin
                            if (erase_suspended) begin
                                r_d.resume = 1'b1;
                                r_d.ident  = 1'b0;
                            end
                        end else
                            abort = 1'b1;
                    end
                    ST_UNL1:  if (key2_hit) r_d.st = ST_UNL2; else abort = 1'b1;
                    ST_UNL2: begin
                        if (cmd_adr && wr_data == CMD_IDENT) begin
                            r_d.st    = ST_IDLE;
                            r_d.ident = 1'b1;
                        end else if (cmd_adr && wr_data == CMD_PGM) begin
                            r_d.st    = ST_PGM;
                            r_d.ident = 1'b0;
                        end else if (cmd_adr && wr_data == CMD_ERASE) begin
                            r_d.st    = ST_EUNL0;
                            r_d.ident = 1'b0;
                        end else
                            abort = 1'b1;
                    end
                    ST_PGM: begin
                        r_d.prog  = 1'b1;
                        r_d.paddr = wr_addr;
                        r_d.pdata = wr_data;
                        r_d.st    = ST_IDLE;
                    end
                    ST_EUNL0: if (key1_hit) r_d.st = ST_EUNL1; else abort = 1'b1;
                    ST_EUNL1: if (key2_hit) r_d.st = ST_EUNL2; else abort = 1'b1;
                    ST_EUNL2: begin
                        if (cmd_adr && wr_data == CMD_BULK) begin
                            r_d.erase = 1'b1;
                            r_d.bulk  = 1'b1;
                            r_d.mask  = '1;
                            r_d.st    = ST_IDLE;
                        end else if (wr_data == CMD_SECTOR) begin
                            r_d.mask = sec_bit;
                            r_d.cnt  = CNT_W'(WIN_CYC - 1);
                            r_d.st   = ST_WIN;
                        end else
                            abort = 1'b1;
                    end
                    ST_WIN: begin
                        if (wr_data == CMD_SECTOR) begin
                            r_d.mask = r_q.mask | sec_bit;
                            r_d.cnt  = CNT_W'(WIN_CYC - 1);
                        end else
                            abort = 1'b1;
                    end
                    default: abort = 1'b1;
                endcase
            end
            if (abort) begin
                r_d.st    = ST_IDLE;
                r_d.ident = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_req      = r_q.prog;
    assign prog_addr     = r_q.paddr;
    assign prog_data     = r_q.pdata;
    assign erase_req     = r_q.erase;
    assign erase_bulk    = r_q.bulk;
    assign erase_sectors = r_q.mask;
    assign suspend_req   = r_q.susp;
    assign resume_req    = r_q.resume;
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [7:0]              wr_data,
    input logic                    erase_busy,
    input logic                    erase_suspended,
    input logic                    prog_req,
    input logic                    erase_req,
    input logic                    erase_bulk,
    input logic [(1<<SECT_W)-1:0]  erase_sectors,
    input logic                    suspend_req,
    input logic                    resume_req
);
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req, suspend_req, resume_req})); // R11
    AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R11
    AST_PROG_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wr_en)); // R3
    AST_BULK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_bulk) |-> (erase_sectors == '1)); // R4
    AST_WIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_bulk) |-> ($past(!wr_en) && $countones(erase_sectors) > 0)); // R5
    AST_SUSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> ($past(erase_busy) && $past(wr_data) == 8'hB0)); // R6
    AST_RESUME_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(erase_suspended)); // R6
endmodule

bind fcd fcd_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (.*);

// File: tb/sim_fcd.sv
module sim_fcd;
    localparam int AW = 19;
    localparam int W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic erase_busy = 1'b0, erase_suspended = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] prot_mask = 8'b0010_0000;
    logic prog_req, erase_req, erase_bulk, suspend_req, resume_req;
    logic [AW-1:0] prog_addr;
    logic [7:0] prog_data, erase_sectors, rd_data;
    logic [1:0] rd_sel;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fcd #(.ADDR_W(AW), .SECT_W(3), .WIN_CYC(W)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [3:0] reqs();
        return {prog_req, erase_req, suspend_req, resume_req};
    endfunction

    task automatic unlock();
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
    endtask

    // {addr, data, exp reqs {prog,erase,susp,resume}, exp ident}
    localparam int NV = 12;
    localparam logic [31:0] VEC [0:NV-1] = '{
        {19'h05555, 8'hAA, 4'b0000, 1'b0},
        {19'h02AAA, 8'h55, 4'b0000, 1'b0},
        {19'h05555, 8'h90, 4'b0000, 1'b1},
        {19'h12345, 8'hF0, 4'b0000, 1'b0},
        {19'h7D555, 8'hAA, 4'b0000, 1'b0},
        {19'h7AAAA, 8'h55, 4'b0000, 1'b0},
        {19'h05555, 8'hA0, 4'b0000, 1'b0},
        {19'h4ABCD, 8'h5A, 4'b1000, 1'b0},
        {19'h05555, 8'hAA, 4'b0000, 1'b0},
        {19'h02AAA, 8'h56, 4'b0000, 1'b0},
        {19'h02AAA, 8'h55, 4'b0000, 1'b0},
        {19'h05555, 8'hB0, 4'b0000, 1'b0}
    };
    function automatic string vtag(input int i);
        case (i)
            2: return "R9 ident entry";
            3: return "R7 reset";
            4, 5, 6: return "R2 high bits ignored";
            7: return "R3 program";
            9, 10: return "R8 abort";
            11: return "R6 ignored suspend";
            default: return "R2 unlock";
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reqs() == 4'b0, "R1 reqs after reset", reqs(), 0);
        chk(rd_sel == 2'b00 && rd_data == 8'h00, "R1 read mode after reset", rd_sel, 0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][31:13], VEC[i][12:5]);
            chk(reqs() == VEC[i][4:1], vtag(i), reqs(), VEC[i][4:1]);
            chk(rd_sel == {1'b0, VEC[i][0]}, vtag(i), rd_sel, VEC[i][0]);
        end

        // R3 program address/data, R11 single pulse
        unlock(); wr(19'h05555, 8'hA0); wr(19'h6F00F, 8'hF0);
        chk(prog_req && prog_addr == 19'h6F00F && prog_data == 8'hF0, "R3 program data F0", prog_addr, 19'h6F00F);
        @(negedge clk);
        chk(reqs() == 4'b0, "R11 request lasts one cycle", reqs(), 0);

        // R4 bulk erase
        unlock(); wr(19'h05555, 8'h80); unlock();
        chk(reqs() == 4'b0, "R4 no request before confirm", reqs(), 0);
        wr(19'h05555, 8'h10);
        chk(erase_req && erase_bulk && erase_sectors == 8'hFF, "R4 bulk erase", erase_sectors, 8'hFF);

        // R5 single sector window timing
        unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h20000, 8'h30);
        for (int j = 1; j < W; j++) @(negedge clk);
        chk(!erase_req, "R5 window still open at WIN_CYC-1", erase_req, 0);
        @(negedge clk);
        chk(erase_req && !erase_bulk && erase_sectors == 8'h04, "R5 sector 2 erase", erase_sectors, 8'h04);

        // R5 accumulation with restart
        unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h20000, 8'h30);
        repeat (3) @(negedge clk);
        wr(19'h51234, 8'h30);
        for (int j = 1; j < W; j++) @(negedge clk);
        chk(!erase_req, "R5 window restarted", erase_req, 0);
        @(negedge clk);
        chk(erase_req && erase_sectors == 8'h24, "R5 sectors 2 and 5", erase_sectors, 8'h24);

        // R8 non-30h write cancels window
        unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h30000, 8'h30);
        wr(19'h30000, 8'h77);
        begin
            bit seen = 0;
            for (int j = 0; j < W + 4; j++) begin
                @(negedge clk);
                if (erase_req) seen = 1;
            end
            chk(!seen, "R8 window cancelled", seen, 0);
        end

        // R7 F0 during erase setup, then stray confirm aborts
        unlock(); wr(19'h05555, 8'h80); wr(19'h00000, 8'hF0);
        wr(19'h05555, 8'h10);
        chk(reqs() == 4'b0, "R7 F0 cancels erase setup", reqs(), 0);

        // R6 suspend / resume
        erase_busy = 1'b1;
        wr(19'h01234, 8'hB0);
        chk(suspend_req, "R6 suspend while busy", reqs(), 4'b0010);
        erase_busy = 1'b0; erase_suspended = 1'b1;
        wr(19'h01234, 8'h30);
        chk(resume_req, "R6 resume while suspended", reqs(), 4'b0001);
        erase_suspended = 1'b0;

        // R9/R10 ident readout, R6 ignored writes keep mode
        unlock(); wr(19'h05555, 8'h90);
        wr(19'h00000, 8'h30);
        wr(19'h00000, 8'hB0);
        chk(reqs() == 4'b0, "R6 ignored resume/suspend", reqs(), 0);
        rd_addr = 19'h00000; #1;
        chk(rd_sel == 2'b01 && rd_data == 8'h20, "R9 maker code after ignored writes", rd_data, 8'h20);
        rd_addr = 19'h00001; #1;
        chk(rd_sel == 2'b01 && rd_data == 8'hE2, "R9 device code", rd_data, 8'hE2);
        rd_addr = 19'h50002; #1;
        chk(rd_sel == 2'b10 && rd_data == 8'h01, "R10 protected sector 5", rd_data, 8'h01);
        rd_addr = 19'h30002; #1;
        chk(rd_sel == 2'b10 && rd_data == 8'h00, "R10 unprotected sector 3", rd_data, 8'h00);
        wr(19'h00000, 8'h12);
        rd_addr = 19'h00000; #1;
        chk(rd_sel == 2'b00, "R8 stray write leaves ident mode", rd_sel, 0);

        // R1 reset mid-sequence
        unlock(); wr(19'h05555, 8'h90);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; #1;
        chk(rd_sel == 2'b00 && reqs() == 4'b0, "R1 reset returns to array", rd_sel, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule